// File: doc/BRIEF.md
# Data-Processing ALU with Condition-Flag Update

This block performs the sixteen two-operand data-processing operations of a 32-bit RISC core's execute stage. The first operand comes from the register file and the second from the barrel shifter, which also supplies its own carry-out. The block returns the result, a register write enable and the next N/Z/C/V flags. When a flag-setting instruction writes the program counter in a mode that owns a saved status register, it raises a request to restore the status from that register instead.

Every issued operation (`op_valid_i` high) is registered on the next rising clock edge, so all outputs appear one cycle after issue. In a cycle with no issue, the block reports no write and no restore, and it keeps the last result and flags. The shifter, the register file and the status registers are all outside the block.

The design has no sequencing states. A single output register process follows the combinational datapath: an operation decoder, a carry-chain adder and a bitwise logic unit.

Top module: `dp_alu`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `result_o`, `wr_en_o`, `flags_o` and `restore_o` are all zero.
- R2: Outputs change one clock edge after issue. In a cycle after a non-issue cycle, `wr_en_o` and `restore_o` are 0 and `result_o` and `flags_o` keep their values.
- R3: Bitwise operations use these codes: 0 AND (Rn & op), 1 EOR (Rn ^ op), C ORR (Rn | op), D MOV (op), E BIC (Rn & ~op), F MVN (~op).
- R4: Code 4 ADD produces Rn + op. Code 5 ADC produces Rn + op + C.
- R5: Code 2 SUB produces Rn - op. Code 3 RSB produces op - Rn. Code 6 SBC produces Rn - op - (1 - C). Code 7 RSC produces op - Rn - (1 - C).
- R6: The flags are packed as {N, Z, C, V} in bits [3:0]. For a flag-setting arithmetic operation, N is result bit 31 and Z is set when the result is zero. C is the unsigned carry-out, which for subtraction is 1 when no borrow occurs. V is the signed overflow.
- R7: For a flag-setting bitwise operation (codes 0, 1, 8, 9, C, D, E, F), N and Z come from the result, C equals `shift_carry_i` and V keeps its input value.
- R8: Codes 8 TST (AND), 9 TEQ (EOR), A CMP (SUB) and B CMN (ADD) set the flags whatever `s_bit_i` is, never assert `wr_en_o`, and still present their value on `result_o`.
- R9: Codes 0-7 and C-F assert `wr_en_o`. When `s_bit_i` is 0, these codes pass `flags_i` unchanged to `flags_o`.
- R10: For an operation that sets flags, with `dest_pc_i` and `has_saved_i` both 1, `restore_o` is 1 and `flags_o` equals `flags_i`. The result and the write enable follow the opcode as usual.
- R11: `restore_o` stays 0 for a flag-setting operation when either `dest_pc_i` or `has_saved_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is issued this cycle |
| opcode_i | input | 4 | Operation code |
| s_bit_i | input | 1 | Set-flags request |
| dest_pc_i | input | 1 | Destination register is the program counter |
| has_saved_i | input | 1 | Current mode has a saved status register |
| rn_i | input | 32 | First operand |
| opnd_i | input | 32 | Shifter operand |
| shift_carry_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next {N,Z,C,V} |
| restore_o | output | 1 | Request to copy saved status into current status |

## Verification
Two functions can coincide in one cycle: the flag computation and the saved-status restore request. Both apply to any flag-setting operation, including compares, which set flags even with `s_bit_i` low. The bench provokes the overlap with directed compare, arithmetic and bitwise operations whose destination is the PC. It runs them both with and without a saved register, then mixes these bits at random into long runs. On every cycle the bench model decides whether the restore wins, and it then expects the flags to pass through unchanged while the result and write enable keep their normal values.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,   // bitwise, carry from shifter
        CLS_ADD   = 2'd1,   // Rn + op
        CLS_SUB   = 2'd2,   // Rn - op
        CLS_RSUB  = 2'd3    // op - Rn
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      cin_from_c;  // carry-in taken from the C flag
        logic      writes;      // destination written
        logic      force_s;     // flags set regardless of S
    } op_ctl_t;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

endpackage

// File: rtl/dp_opdecode.sv
module dp_opdecode
    import dp_alu_pkg::*;
(
    input  alu_op_e op_i,
    output op_ctl_t ctl_o
);
    always_comb begin
        ctl_o = '{cls: CLS_LOGIC, cin_from_c: 1'b0, writes: 1'b1, force_s: 1'b0};
        unique case (op_i)
            OP_SUB: ctl_o.cls = CLS_SUB;
            OP_RSB: ctl_o.cls = CLS_RSUB;
            OP_ADD: ctl_o.cls = CLS_ADD;
            OP_ADC: begin ctl_o.cls = CLS_ADD;  ctl_o.cin_from_c = 1'b1; end
            OP_SBC: begin ctl_o.cls = CLS_SUB;  ctl_o.cin_from_c = 1'b1; end
            OP_RSC: begin ctl_o.cls = CLS_RSUB; ctl_o.cin_from_c = 1'b1; end
            OP_TST, OP_TEQ: begin
                ctl_o.writes  = 1'b0;
                ctl_o.force_s = 1'b1;
            end
            OP_CMP: begin
                ctl_o.cls = CLS_SUB; ctl_o.writes = 1'b0; ctl_o.force_s = 1'b1;
            end
            OP_CMN: begin
                ctl_o.cls = CLS_ADD; ctl_o.writes = 1'b0; ctl_o.force_s = 1'b1;
            end
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dp_adder.sv
module dp_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;
    logic [WIDTH:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (a_i[MSB] == b_i[MSB]) && (full[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] opnd_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = rn_i & opnd_i;
            OP_EOR, OP_TEQ: res_o = rn_i ^ opnd_i;
            OP_ORR:         res_o = rn_i | opnd_i;
            OP_MOV:         res_o = opnd_i;
            OP_BIC:         res_o = rn_i & ~opnd_i;
            OP_MVN:         res_o = ~opnd_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid_i,
    input  logic [3:0]       opcode_i,
    input  logic             s_bit_i,
    input  logic             dest_pc_i,
    input  logic             has_saved_i,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             shift_carry_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [NFLAG-1:0] flags_o,
    output logic             restore_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    op_ctl_t          ctl;
    logic [WIDTH-1:0] add_a, add_b, add_sum, logic_res, res_d;
    logic             add_cin, add_cout, add_ovf;
    logic             s_eff, restore_d;
    logic [NFLAG-1:0] flags_d;

    assign op = alu_op_e'(opcode_i);

    dp_opdecode u_dec (.op_i(op), .ctl_o(ctl));

    // Operand steering: subtraction is a + ~b + carry-in
    always_comb begin
        unique case (ctl.cls)
            CLS_SUB:  begin add_a = rn_i;   add_b = ~opnd_i; end
            CLS_RSUB: begin add_a = opnd_i; add_b = ~rn_i;   end
            default:  begin add_a = rn_i;   add_b = opnd_i;  end
        endcase
        if (ctl.cin_from_c)
            add_cin = flags_i[FLAG_C];
        else
            add_cin = (ctl.cls == CLS_SUB) || (ctl.cls == CLS_RSUB);
    end

    dp_adder #(.WIDTH(WIDTH)) u_add (
        .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    dp_logic #(.WIDTH(WIDTH)) u_log (
        .op_i(op), .rn_i(rn_i), .opnd_i(opnd_i), .res_o(logic_res)
    );

    always_comb begin
        res_d     = (ctl.cls == CLS_LOGIC) ? logic_res : add_sum;
        s_eff     = s_bit_i | ctl.force_s;
        restore_d = s_eff & dest_pc_i & has_saved_i;
        flags_d   = flags_i;
        if (s_eff && !restore_d) begin
            flags_d[FLAG_N] = res_d[MSB];
            flags_d[FLAG_Z] = (res_d == '0);
            if (ctl.cls == CLS_LOGIC) begin
                flags_d[FLAG_C] = shift_carry_i;
            end else begin
                flags_d[FLAG_C] = add_cout;
                flags_d[FLAG_V] = add_ovf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            flags_o   <= '0;
            restore_o <= 1'b0;
        end else if (op_valid_i) begin
            result_o  <= res_d;
            wr_en_o   <= ctl.writes;
            flags_o   <= flags_d;
            restore_o <= restore_d;
        end else begin
            wr_en_o   <= 1'b0;
            restore_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int WIDTH = 32,
    parameter int NFLAG = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid_i,
    input logic [3:0]       opcode_i,
    input logic             s_bit_i,
    input logic             dest_pc_i,
    input logic             has_saved_i,
    input logic [WIDTH-1:0] rn_i,
    input logic [WIDTH-1:0] opnd_i,
    input logic             shift_carry_i,
    input logic [NFLAG-1:0] flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic [NFLAG-1:0] flags_o,
    input logic             restore_o
);
    logic is_cmp, is_logic, s_eff, rest_cond;
    assign is_cmp    = (opcode_i[3:2] == 2'b10);
    assign is_logic  = (opcode_i[3:2] == 2'b11) || (opcode_i[3:1] == 3'b000)
                       || (opcode_i[3:1] == 3'b100);
    assign s_eff     = s_bit_i | is_cmp;
    assign rest_cond = s_eff & dest_pc_i & has_saved_i;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> (!wr_en_o && !restore_o)); // R2
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && is_cmp) |=> !wr_en_o); // R8
    AST_NOS_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !s_eff) |=> (flags_o == $past(flags_i))); // R9
    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && s_eff && is_logic && !rest_cond)
        |=> (flags_o[0] == $past(flags_i[0]) && flags_o[1] == $past(shift_carry_i))); // R7
    AST_RESTORE_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && rest_cond) |=> (restore_o && flags_o == $past(flags_i))); // R10
    AST_NO_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !rest_cond) |=> !restore_o); // R11
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && s_eff && !rest_cond) |=> (flags_o[2] == (result_o == '0))); // R6
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH), .NFLAG(NFLAG)) u_chk (.*);

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic [3:0]  opcode_i = 4'h0;
    logic        s_bit_i = 1'b0, dest_pc_i = 1'b0, has_saved_i = 1'b0;
    logic [31:0] rn_i = '0, opnd_i = '0;
    logic        shift_carry_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o, restore_o;
    logic [3:0]  flags_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] e_res = '0;
    logic        e_wr = 0, e_rst = 0;
    logic [3:0]  e_flg = '0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    dp_alu u_dp_alu (.*);

    task automatic check();
        total++;
        if (result_o !== e_res || wr_en_o !== e_wr || flags_o !== e_flg || restore_o !== e_rst) begin
            bad++;
            $display("FAIL %s: got res=%h wr=%b flg=%h rst=%b exp res=%h wr=%b flg=%h rst=%b",
                     e_tag, result_o, wr_en_o, flags_o, restore_o, e_res, e_wr, e_flg, e_rst);
        end
    endtask

    // Behavioural model of one issue, applied to the expectation registers
    task automatic model();
        longint unsigned a, b, cin, wide;
        longint sa, sb, sw;
        bit arith, cmp, s, rs, c;
        logic [31:0] r;
        c = flags_i[1];
        if (!op_valid_i) begin
            e_wr = 0; e_rst = 0; e_tag = "R2";
            return;
        end
        cmp   = (opcode_i >= 4'h8 && opcode_i <= 4'hB);
        arith = (opcode_i >= 4'h2 && opcode_i <= 4'h7) || opcode_i == 4'hA || opcode_i == 4'hB;
        s     = s_bit_i || cmp;
        rs    = s && dest_pc_i && has_saved_i;
        a = 0; b = 0; cin = 0; sa = 0; sb = 0; wide = 0; sw = 0;
        case (opcode_i)
            4'h0, 4'h8: r = rn_i & opnd_i;
            4'h1, 4'h9: r = rn_i ^ opnd_i;
            4'hC: r = rn_i | opnd_i;
            4'hD: r = opnd_i;
            4'hE: r = rn_i & ~opnd_i;
            4'hF: r = ~opnd_i;
            default: begin
                bit rev, sub;
                sub = !(opcode_i == 4'h4 || opcode_i == 4'h5 || opcode_i == 4'hB);
                rev = (opcode_i == 4'h3 || opcode_i == 4'h7);
                a  = rev ? opnd_i : rn_i;
                b  = rev ? rn_i : opnd_i;
                sa = longint'($signed(rev ? opnd_i : rn_i));
                sb = longint'($signed(rev ? rn_i : opnd_i));
                if (!sub) begin
                    cin  = (opcode_i == 4'h5) ? c : 0;
                    wide = a + b + cin;
                    sw   = sa + sb + longint'(cin);
                end else begin
                    cin  = (opcode_i == 4'h6 || opcode_i == 4'h7) ? (1 - c) : 0;
                    wide = a - b - cin;
                    sw   = sa - sb - longint'(cin);
                end
                r = wide[31:0];
                if (sub) wide[32] = (a >= b + cin);
                else     wide[32] = (a + b + cin) > 64'hFFFF_FFFF;
            end
        endcase
        e_res = r;
        e_wr  = !cmp;
        e_rst = rs;
        e_flg = flags_i;
        if (s && !rs) begin
            e_flg[3] = r[31];
            e_flg[2] = (r == 0);
            if (arith) begin
                e_flg[1] = wide[32];
                e_flg[0] = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
            end else begin
                e_flg[1] = shift_carry_i;
            end
        end
        if (rs)             e_tag = "R10";
        else if (s && s_bit_i && (dest_pc_i ^ has_saved_i)) e_tag = "R11";
        else if (cmp)       e_tag = "R8";
        else if (!s)        e_tag = "R9";
        else if (!arith)    e_tag = "R7";
        else                e_tag = "R6";
    endtask

    task automatic issue(input bit v, input logic [3:0] op, input bit s, input bit pc,
                         input bit sv, input logic [31:0] a, input logic [31:0] b,
                         input bit sc, input logic [3:0] f);
        op_valid_i = v; opcode_i = op; s_bit_i = s; dest_pc_i = pc; has_saved_i = sv;
        rn_i = a; opnd_i = b; shift_carry_i = sc; flags_i = f;
        model();
        @(negedge clk);
        check();
    endtask

    initial begin
        #80000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung exp finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        e_tag = "R1"; check();                    // R1 during reset
        rst = 1'b0;
        @(negedge clk); e_tag = "R1"; check();    // R1 right after release
        // R3 bitwise results, S clear
        issue(1, 4'h0, 0, 0, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 4'h0);
        issue(1, 4'h1, 0, 0, 0, 32'hAAAA_5555, 32'hFFFF_0000, 0, 4'h5);
        issue(1, 4'hC, 0, 0, 0, 32'h1200_0000, 32'h0000_0034, 0, 4'h0);
        issue(1, 4'hD, 0, 0, 0, 32'h1111_1111, 32'hDEAD_BEEF, 0, 4'h0);
        issue(1, 4'hE, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 4'h0);
        issue(1, 4'hF, 0, 0, 0, 32'h0, 32'h0000_0000, 0, 4'h0);
        // R2 idle holds result and flags
        issue(0, 4'h4, 1, 0, 0, 32'h5, 32'h5, 0, 4'hF);
        // R4 add cases with flags R6
        issue(1, 4'h4, 1, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 4'h0);
        issue(1, 4'h4, 1, 0, 0, 32'hFFFF_FFFF, 32'h1, 0, 4'h0);
        issue(1, 4'h5, 1, 0, 0, 32'h10, 32'h20, 0, 4'h2);
        // R5 subtract family
        issue(1, 4'h2, 1, 0, 0, 32'h5, 32'h5, 0, 4'h0);
        issue(1, 4'h2, 1, 0, 0, 32'h0, 32'h1, 0, 4'h0);
        issue(1, 4'h3, 1, 0, 0, 32'h3, 32'h10, 0, 4'h0);
        issue(1, 4'h6, 1, 0, 0, 32'h10, 32'h3, 0, 4'h0);
        issue(1, 4'h7, 1, 0, 0, 32'h3, 32'h10, 0, 4'h2);
        issue(1, 4'h2, 1, 0, 0, 32'h8000_0000, 32'h1, 0, 4'h0);
        // R7 bitwise flags with shifter carry, V kept
        issue(1, 4'hD, 1, 0, 0, 32'h0, 32'h0, 1, 4'h1);
        issue(1, 4'h0, 1, 0, 0, 32'h8000_0000, 32'h8000_0001, 0, 4'h3);
        // R8 compares with S clear
        issue(1, 4'hA, 0, 0, 0, 32'h7, 32'h7, 0, 4'h0);
        issue(1, 4'hB, 0, 0, 0, 32'hFFFF_FFFF, 32'h1, 0, 4'h0);
        issue(1, 4'h8, 0, 0, 0, 32'hF0, 32'h0F, 1, 4'h1);
        issue(1, 4'h9, 0, 0, 0, 32'h1, 32'h1, 0, 4'h8);
        // R10 restore colliding with flag update; R11 partial conditions
        issue(1, 4'h2, 1, 1, 1, 32'h5, 32'h5, 0, 4'h9);
        issue(1, 4'hA, 0, 1, 1, 32'h0, 32'h1, 0, 4'h6);
        issue(1, 4'hD, 1, 1, 1, 32'h0, 32'h0, 1, 4'h0);
        issue(1, 4'h2, 1, 1, 0, 32'h5, 32'h5, 0, 4'h9);
        issue(1, 4'h2, 1, 0, 1, 32'h5, 32'h5, 0, 4'h9);
        issue(1, 4'h4, 0, 1, 1, 32'h1, 32'h1, 0, 4'hA);  // S clear: no restore (R11 via R9 path)
        issue(0, 4'h2, 1, 1, 1, 32'h0, 32'h0, 0, 4'h0);  // R2 idle with restore bits
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            int sel;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? 32'h0 : (sel == 1) ? 32'hFFFF_FFFF : $urandom;
            b = (sel == 2) ? a : $urandom;
            issue($urandom_range(0, 7) != 0, 4'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), a, b, 1'($urandom), 4'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule